// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-driven copy or parity engine and decides when the engine should post a completion interrupt message. Each cycle the engine presents the number of finished descriptors that software has not yet handled. The block does not raise an interrupt for every completion. It waits until that backlog reaches a programmed count. If the aging timer is switched on, it also fires once a smaller backlog has waited a programmed number of clock cycles.

A firing produces a single-cycle strobe with a 48-bit message address and a 32-bit message payload. Both values come from configuration registers. After a firing the block holds off until the backlog value moves, either because new work completed or because software released descriptors. This keeps a static backlog from producing a stream of repeated messages.

Configuration arrives as simple single-cycle register writes with a 12-bit offset. Writes to unmapped offsets are dropped.

Top module: `irq_coalescer`

## Requirements
- R1: While reset is asserted the strobe is low and the message address and payload outputs are zero. After reset the count threshold is 20, the timeout is 176 and the timer is off.
- R2: With the block armed and a nonzero backlog at or above the count threshold, the strobe rises on the clock edge after the backlog is sampled there.
- R3: A backlog of zero never produces a message, whatever the threshold, timeout or timer setting.
- R4: With the timer on and the timeout set to T, a backlog held nonzero and below the threshold produces a strobe on the (T+1)th clock edge after its first sampling edge.
- R5: With the timer off, a backlog below the threshold produces no message, however long it is held.
- R6: The aging count restarts whenever the backlog returns to zero. A later nonzero backlog waits the full timeout again.
- R7: After a firing, no further message is produced while the backlog keeps the value it had when the block fired. Any change of that value re-arms the block at once.
- R8: When the count and the timeout are met in the same cycle, exactly one strobe is produced.
- R9: Register writes are decoded as follows:
  - Offset 0x018: count threshold in bits [14:0], timer enable in bit 18.
  - Offset 0x810: timeout in bits [12:0].
  - Offset 0x050: low 32 address bits.
  - Offset 0x054: bits [15:0] are the upper 16 address bits.
  - Offset 0x014: message payload.
  - Register bits outside these fields are ignored.
  - The address and payload captured at the firing edge appear with the strobe.
- R10: The strobe lasts one cycle for a firing whose backlog then stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| pend_cnt | input | 15 | Completed, not yet handled descriptor count |
| msg_valid | output | 1 | One-cycle interrupt message strobe |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The bench aims at these corner cases:
- A backlog that drops to zero in the middle of its aging window. A design that keeps the old age would fire early at the wrong cycle.
- A threshold crossing that lands on the same cycle the timer expires. A design that treats the two paths separately would emit a duplicate strobe.
- A static backlog after a firing. A design that re-arms too eagerly would emit a message every cycle, and one that never re-arms would miss the next change.
- Zero backlog with a zero threshold and zero timeout, which catches a missing nonzero guard.
- Writes carrying stray high bits, which catch a wrong field mask or a misplaced timer-enable bit.

// File: rtl/coal_pkg.sv
// Package: shared widths and register offsets for the interrupt coalescer.
// Assumes a 12-bit register offset space and a 48-bit message address.
package coal_pkg;
    localparam int CFG_AW     = 12;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 15;
    localparam int TMO_W      = 13;
    localparam int MSG_AW     = 48;
    localparam int ADDR_HI_W  = MSG_AW - DATA_W;
    localparam int TMR_EN_BIT = 18;

    localparam logic [CFG_AW-1:0] OFS_THR  = 12'h018;
    localparam logic [CFG_AW-1:0] OFS_TMO  = 12'h810;
    localparam logic [CFG_AW-1:0] OFS_ALO  = 12'h050;
    localparam logic [CFG_AW-1:0] OFS_AHI  = 12'h054;
    localparam logic [CFG_AW-1:0] OFS_DATA = 12'h014;

    typedef struct packed {
        logic [CNT_W-1:0] thr;
        logic             tmr_en;
        logic [TMO_W-1:0] tmo;
    } coal_cfg_t;

    typedef struct packed {
        logic [MSG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } coal_msg_t;
endpackage

// File: rtl/coal_cfg_regs.sv
// Module: configuration register file of the coalescer.
// Decodes single-cycle writes into threshold, timer enable, timeout and
// the message address/payload template. Unmapped offsets are dropped.
module coal_cfg_regs
    import coal_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_THR = 15'h0014,
    parameter logic [TMO_W-1:0] RST_TMO = 13'h00B0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output coal_cfg_t         cfg,
    output coal_msg_t         tpl
);
    logic [DATA_W-1:0]    addr_lo_q;
    logic [ADDR_HI_W-1:0] addr_hi_q;
    logic [DATA_W-1:0]    data_q;
    coal_cfg_t            cfg_q;

    // Register update on a write strobe; reset loads the default tuning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.thr    <= RST_THR;
            cfg_q.tmr_en <= 1'b0;
            cfg_q.tmo    <= RST_TMO;
            addr_lo_q    <= '0;
            addr_hi_q    <= '0;
            data_q       <= '0;
        end else if (we) begin
            case (addr)
                OFS_THR: begin
                    cfg_q.thr    <= wdata[CNT_W-1:0];
                    cfg_q.tmr_en <= wdata[TMR_EN_BIT];
                end
                OFS_TMO:  cfg_q.tmo <= wdata[TMO_W-1:0];
                OFS_ALO:  addr_lo_q <= wdata;
                OFS_AHI:  addr_hi_q <= wdata[ADDR_HI_W-1:0];
                OFS_DATA: data_q    <= wdata;
                default:  ;
            endcase
        end
    end

    // Present the message template as one packed value.
    always_comb begin
        cfg       = cfg_q;
        tpl.addr  = {addr_hi_q, addr_lo_q};
        tpl.data  = data_q;
    end
endmodule

// File: rtl/coal_age_timer.sv
// Module: aging counter for a small completion backlog.
// Counts cycles while the block is armed and the backlog is nonzero and
// below the count threshold; restarts on zero backlog, on a firing and
// while disarmed. Saturates at its maximum so it never wraps.
module coal_age_timer
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pend,
    input  logic [CNT_W-1:0] thr,
    input  logic             tmr_en,
    input  logic [TMO_W-1:0] tmo,
    input  logic             armed,
    input  logic             clr,
    output logic             timeout_hit
);
    localparam logic [TMO_W-1:0] AGE_MAX = '1;

    logic [TMO_W-1:0] age_q;
    logic             small_backlog;

    // Backlog that only the timer can turn into a message.
    always_comb small_backlog = (pend != '0) && (pend < thr);

    // Age register: clear, count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if ((pend == '0) || clr || !armed) begin
            age_q <= '0;
        end else if (small_backlog && (age_q != AGE_MAX)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Expiry flag for the firing decision.
    always_comb timeout_hit = tmr_en && (pend != '0) && (age_q >= tmo);

    p_age_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (age_q == '0));

    p_age_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (small_backlog && armed && !clr && (age_q != AGE_MAX))
        |=> (age_q == $past(age_q) + 1'b1));
endmodule

// File: rtl/coal_fire_ctl.sv
// Module: firing decision, re-arm tracking and message output register.
// The block is armed after reset and disarmed by a firing; it re-arms as
// soon as the backlog differs from the value it had when it fired.
module coal_fire_ctl
    import coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  pend,
    input  logic [CNT_W-1:0]  thr,
    input  logic              timeout_hit,
    input  coal_msg_t         tpl,
    output logic              armed_eff,
    output logic              fire,
    output logic              msg_valid,
    output logic [MSG_AW-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    logic             armed_q;
    logic [CNT_W-1:0] snap_q;
    logic             count_hit;

    // Armed now if never disarmed, or if the backlog moved since firing.
    always_comb armed_eff = armed_q || (pend != snap_q);

    // Count path and the single merged firing condition.
    always_comb begin
        count_hit = (pend != '0) && (pend >= thr);
        fire      = armed_eff && (count_hit || timeout_hit);
    end

    // Arm state and backlog snapshot taken on each firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            snap_q  <= '0;
        end else begin
            armed_q <= fire ? 1'b0 : armed_eff;
            if (fire) snap_q <= pend;
        end
    end

    // Message output register: strobe plus captured address and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= fire;
            if (fire) begin
                msg_addr <= tpl.addr;
                msg_data <= tpl.data;
            end
        end
    end

    p_no_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(pend) != '0));

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (pend == $past(pend))) |=> !msg_valid);

    p_count_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_eff && (pend != '0) && (pend >= thr)) |=> msg_valid);

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_hit && (pend < thr)) |=> !msg_valid);
endmodule

// File: rtl/irq_coalescer.sv
// Module: completion interrupt coalescer top.
// Turns a backlog of finished descriptors into rare one-cycle interrupt
// messages using a count threshold and an optional aging timer.
// Assumes pend_cnt is synchronous to clk.
module irq_coalescer
    import coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [14:0]       pend_cnt,
    output logic              msg_valid,
    output logic [47:0]       msg_addr,
    output logic [31:0]       msg_data
);
    coal_cfg_t cfg;
    coal_msg_t tpl;
    logic      armed_eff;
    logic      fire;
    logic      timeout_hit;

    coal_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .tpl   (tpl)
    );

    coal_age_timer u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend_cnt),
        .thr         (cfg.thr),
        .tmr_en      (cfg.tmr_en),
        .tmo         (cfg.tmo),
        .armed       (armed_eff),
        .clr         (fire),
        .timeout_hit (timeout_hit)
    );

    coal_fire_ctl u_fire (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend_cnt),
        .thr         (cfg.thr),
        .timeout_hit (timeout_hit),
        .tpl         (tpl),
        .armed_eff   (armed_eff),
        .fire        (fire),
        .msg_valid   (msg_valid),
        .msg_addr    (msg_addr),
        .msg_data    (msg_data)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && (msg_addr == '0) && (msg_data == '0)));
endmodule

// File: tb/irq_coalescer_tb_top.sv
// Scoreboard bench: the driver queues expected messages, the monitor
// pops and compares each strobe it sees.
module irq_coalescer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [14:0] pend_cnt;
    logic        msg_valid;
    logic [47:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    bit done   = 0;
    string cur_tag = "R1";

    logic [47:0] m_addr = '0;
    logic [31:0] m_data = '0;

    typedef struct {
        int          at;
        logic [47:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    irq_coalescer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pend_cnt  (pend_cnt),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: every strobe must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && msg_valid === 1'b1) begin
            if (q.size() == 0) begin
                check(0, cur_tag, "unexpected strobe at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.at && msg_addr == e.addr && msg_data == e.data,
                      e.tag, "strobe cycle", cyc, e.at);
                if (msg_addr != e.addr)
                    $display("  addr actual=0x%0h expected=0x%0h", msg_addr, e.addr);
                if (msg_data != e.data)
                    $display("  data actual=0x%0h expected=0x%0h", msg_data, e.data);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_at(input int at, input string tag);
        q.push_back('{at, m_addr, m_data, tag});
    endtask

    task automatic drained(input string tag);
        check(q.size() == 0, tag, "missing strobes", q.size(), 0);
        q.delete();
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int c;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pend_cnt = '0;
        step(3);
        // R1: reset state of the outputs
        check(msg_valid == 1'b0, "R1", "msg_valid in reset", msg_valid, 0);
        check(msg_addr == '0, "R1", "msg_addr in reset", msg_addr, 0);
        check(msg_data == '0, "R1", "msg_data in reset", msg_data, 0);
        rst_n = 1'b1;

        // R3: zero threshold, timer on, zero timeout, zero backlog
        cur_tag = "R3";
        wr(12'h018, 32'h0004_0000);
        wr(12'h810, 32'h0000_0000);
        step(30);
        drained("R3");

        // R9: program template; stray high bits must be ignored
        cur_tag = "R9";
        wr(12'h050, 32'h89AB_CDEF);
        wr(12'h054, 32'hFFFF_1234);
        wr(12'h014, 32'hCAFE_0001);
        m_addr = 48'h1234_89AB_CDEF;
        m_data = 32'hCAFE_0001;
        wr(12'h018, 32'h0000_8004);   // threshold 4, bit 15 dropped, timer off
        wr(12'h810, 32'h0000_E00A);   // timeout 10 after masking to [12:0]

        // R5: timer off, backlog below threshold for a long time
        cur_tag = "R5";
        step(1); pend_cnt = 15'd3;
        step(40);
        drained("R5");

        // R2 / R10: crossing the threshold
        cur_tag = "R2";
        pend_cnt = 15'd4; c = cyc;
        expect_at(c + 1, "R2");
        step(2);
        check(msg_valid == 1'b0, "R10", "strobe width", msg_valid, 0);
        // R7: static backlog after firing
        cur_tag = "R7";
        step(10);
        drained("R7");
        pend_cnt = 15'd6; c = cyc;
        expect_at(c + 1, "R7");
        step(10);
        drained("R7");
        pend_cnt = 15'd0; step(3);

        // R4: aging path with timeout 10
        cur_tag = "R4";
        wr(12'h018, 32'h0004_0004);
        step(1); pend_cnt = 15'd2; c = cyc;
        expect_at(c + 11, "R4");
        step(25);
        drained("R4");
        pend_cnt = 15'd0; step(3);

        // R6: backlog drops to zero mid-window, timer restarts
        cur_tag = "R6";
        pend_cnt = 15'd1; c = cyc;
        step(6);
        pend_cnt = 15'd0;
        step(2);
        pend_cnt = 15'd1; c = cyc;
        expect_at(c + 11, "R6");
        step(20);
        drained("R6");
        pend_cnt = 15'd0; step(3);

        // R8: count and timeout met together
        cur_tag = "R8";
        wr(12'h810, 32'h0000_0003);
        step(1); pend_cnt = 15'd3; c = cyc;
        step(3);
        pend_cnt = 15'd4;
        expect_at(c + 4, "R8");
        step(12);
        drained("R8");
        pend_cnt = 15'd0; step(3);

        // R9: new template captured on the firing edge
        cur_tag = "R9";
        wr(12'h014, 32'h1357_2468);
        wr(12'h054, 32'h0000_ABCD);
        m_addr = 48'hABCD_89AB_CDEF;
        m_data = 32'h1357_2468;
        step(1); pend_cnt = 15'd5; c = cyc;
        expect_at(c + 1, "R9");
        step(5);
        drained("R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule